// File: doc/BRIEF.md
# Global-History Correlated Branch Direction Predictor

This block guesses whether a conditional branch will be taken. Its guess depends on the branch's own address and on the outcomes of the branches resolved just before it. One history register is shared by every branch. Each resolved outcome is shifted into that register. A table of 2-bit saturating counters holds the learned behaviour. The table is indexed by a mix of fetch-address bits and the history register. Because of this, one branch reached along different paths trains different counters.

The fetch stage presents an address and gets a direction guess back in the same cycle. With the guess it also gets the history value that produced it. When the branch later resolves, the pipeline sends back four things: the branch address, that history snapshot, the real outcome, and a valid strobe. The block then trains the counter the snapshot selects and shifts the outcome into the live history.

Two indexing schemes are selectable at run time:
- **Partitioned:** history bits pick a sub-table and address bits pick the row within it.
- **Hashed:** address bits are XORed with the history.

Top module: `gbp_top`

## Requirements
- R1: After reset the history register is zero and every counter holds 01, so every prediction is not-taken in both modes.
- R2: `pred_taken_o` is bit 1 of the counter selected by the current fetch address, the current history and `mode_i`. It appears combinationally in the same cycle.
- R3: On a cycle with `upd_valid_i` high, the history becomes `{hist[HIST_W-2:0], upd_taken_i}` after the clock edge. Without an update it holds its value.
- R4: A counter saturates: a taken outcome at 11 leaves 11, and a not-taken outcome at 00 leaves 00. Otherwise a taken outcome adds one and a not-taken outcome subtracts one.
- R5: A counter in a strong state needs two consecutive opposite outcomes before its prediction changes. One excursion from the dominant direction leaves the prediction unchanged.
- R6: With `mode_i` = 0 (partitioned), the index is `{hist[PART_HIST_W-1:0], pc[PC_LSB +: IDX_W-PART_HIST_W]}`.
- R7: With `mode_i` = 1 (hashed), the index is `pc[PC_LSB +: IDX_W]` XOR the history zero-extended to IDX_W bits. The defaults give a 2048-entry table from 11 address bits and 8 history bits.
- R8: Training uses the index formed from `upd_pc_i`, `upd_hist_i` and `mode_i`, not the live history.
- R9: When a fetch and an update select the same counter in one cycle, the fetch sees the counter's value from before that update.
- R10: `pred_hist_o` always equals the live history register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 1 | Index scheme: 0 partitioned, 1 hashed |
| fetch_pc_i | input | PC_W | Fetch address to predict |
| pred_taken_o | output | 1 | Predicted direction, 1 = taken |
| pred_hist_o | output | HIST_W | History snapshot used for this prediction |
| upd_valid_i | input | 1 | A branch resolved this cycle |
| upd_pc_i | input | PC_W | Address of the resolved branch |
| upd_hist_i | input | HIST_W | History snapshot returned at its prediction |
| upd_taken_i | input | 1 | Actual outcome, 1 = taken |

## Verification
The bench uses the default parameters:
- a 32-bit address with a 2-bit alignment drop;
- 11 index bits, which gives a 2048-entry table;
- 8 history bits, of which 4 choose the partitioned sub-table.

This makes both index formulas fully exercised. It also gives a short history: a directed sequence of eight updates can place any chosen snapshot value in the live register. That is how the bench steers fetches onto counters that were trained through an unrelated snapshot. The eight-bit width also keeps the collision between fetch and update indexes, including the same-cycle case, cheap to set up.

// File: rtl/gbp_pkg.sv
package gbp_pkg;

    typedef enum logic {
        IDX_PART = 1'b0,
        IDX_HASH = 1'b1
    } idx_mode_e;

    typedef logic [1:0] ctr_t;

    localparam ctr_t CTR_RESET  = 2'b01;
    localparam ctr_t CTR_MAX    = 2'b11;
    localparam ctr_t CTR_MIN    = 2'b00;

    typedef struct packed {
        logic dir;
        ctr_t ctr;
    } lookup_t;

    function automatic ctr_t ctr_train(input ctr_t c, input logic taken);
        ctr_t r;
        if (taken) begin
            r = (c == CTR_MAX) ? CTR_MAX : c + 2'd1;
        end else begin
            r = (c == CTR_MIN) ? CTR_MIN : c - 2'd1;
        end
        return r;
    endfunction

    function automatic lookup_t ctr_lookup(input ctr_t c);
        lookup_t l;
        l.dir = c[1];
        l.ctr = c;
        return l;
    endfunction

endpackage

// File: rtl/gbp_history.sv
module gbp_history #(
    parameter int HIST_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic [HIST_W-1:0] hist
);
    logic [HIST_W-1:0] hist_q;

    generate
        if (HIST_W == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) begin
                    hist_q <= '0;
                end else if (shift_en) begin
                    hist_q <= bit_in;
                end
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) begin
                    hist_q <= '0;
                end else if (shift_en) begin
                    hist_q <= {hist_q[HIST_W-2:0], bit_in};
                end
            end
        end
    endgenerate

    assign hist = hist_q;
endmodule

// File: rtl/gbp_index.sv
module gbp_index
    import gbp_pkg::*;
#(
    parameter int IDX_W       = 11,
    parameter int HIST_W      = 8,
    parameter int PART_HIST_W = 4
) (
    input  idx_mode_e          mode,
    input  logic [IDX_W-1:0]   pc_bits,
    input  logic [HIST_W-1:0]  hist,
    output logic [IDX_W-1:0]   idx
);
    localparam int ROW_W = IDX_W - PART_HIST_W;

    logic [IDX_W-1:0] hist_ext;
    logic [IDX_W-1:0] idx_part;
    logic [IDX_W-1:0] idx_hash;

    generate
        if (HIST_W >= IDX_W) begin : g_hist_trunc
            assign hist_ext = hist[IDX_W-1:0];
        end else begin : g_hist_pad
            assign hist_ext = {{(IDX_W-HIST_W){1'b0}}, hist};
        end
    endgenerate

    assign idx_part = {hist[PART_HIST_W-1:0], pc_bits[ROW_W-1:0]};
    assign idx_hash = pc_bits ^ hist_ext;

    always_comb begin
        unique case (mode)
            IDX_PART: idx = idx_part;
            IDX_HASH: idx = idx_hash;
            default:  idx = idx_part;
        endcase
    end
endmodule

// File: rtl/gbp_pht.sv
module gbp_pht
    import gbp_pkg::*;
#(
    parameter int IDX_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output ctr_t             rd_ctr,
    input  logic [IDX_W-1:0] trn_idx,
    output ctr_t             trn_ctr,
    input  logic             wr_en,
    input  ctr_t             wr_ctr
);
    localparam int DEPTH = 1 << IDX_W;

    ctr_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= CTR_RESET;
            end
        end else if (wr_en) begin
            mem[trn_idx] <= wr_ctr;
        end
    end

    assign rd_ctr  = mem[rd_idx];
    assign trn_ctr = mem[trn_idx];
endmodule

// File: rtl/gbp_top.sv
module gbp_top
    import gbp_pkg::*;
#(
    parameter int PC_W        = 32,
    parameter int PC_LSB      = 2,
    parameter int IDX_W       = 11,
    parameter int HIST_W      = 8,
    parameter int PART_HIST_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_i,
    input  logic [PC_W-1:0]   fetch_pc_i,
    output logic              pred_taken_o,
    output logic [HIST_W-1:0] pred_hist_o,
    input  logic              upd_valid_i,
    input  logic [PC_W-1:0]   upd_pc_i,
    input  logic [HIST_W-1:0] upd_hist_i,
    input  logic              upd_taken_i
);
    idx_mode_e         mode;
    logic [HIST_W-1:0] ghr;
    logic [IDX_W-1:0]  fetch_idx;
    logic [IDX_W-1:0]  upd_idx;
    ctr_t              fetch_ctr;
    ctr_t              upd_ctr_old;
    ctr_t              upd_ctr_new;
    lookup_t           fetch_look;

    assign mode = idx_mode_e'(mode_i);

    gbp_history #(.HIST_W(HIST_W)) u_hist (
        .clk      (clk),
        .rst      (rst),
        .shift_en (upd_valid_i),
        .bit_in   (upd_taken_i),
        .hist     (ghr)
    );

    gbp_index #(.IDX_W(IDX_W), .HIST_W(HIST_W), .PART_HIST_W(PART_HIST_W)) u_fidx (
        .mode    (mode),
        .pc_bits (fetch_pc_i[PC_LSB +: IDX_W]),
        .hist    (ghr),
        .idx     (fetch_idx)
    );

    gbp_index #(.IDX_W(IDX_W), .HIST_W(HIST_W), .PART_HIST_W(PART_HIST_W)) u_uidx (
        .mode    (mode),
        .pc_bits (upd_pc_i[PC_LSB +: IDX_W]),
        .hist    (upd_hist_i),
        .idx     (upd_idx)
    );

    gbp_pht #(.IDX_W(IDX_W)) u_pht (
        .clk     (clk),
        .rst     (rst),
        .rd_idx  (fetch_idx),
        .rd_ctr  (fetch_ctr),
        .trn_idx (upd_idx),
        .trn_ctr (upd_ctr_old),
        .wr_en   (upd_valid_i),
        .wr_ctr  (upd_ctr_new)
    );

    assign upd_ctr_new  = ctr_train(upd_ctr_old, upd_taken_i);
    assign fetch_look   = ctr_lookup(fetch_ctr);
    assign pred_taken_o = fetch_look.dir;
    assign pred_hist_o  = ghr;
endmodule

// File: rtl/gbp_checker.sv
module gbp_checker
    import gbp_pkg::*;
#(
    parameter int IDX_W  = 11,
    parameter int HIST_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              upd_valid_i,
    input logic              upd_taken_i,
    input logic [HIST_W-1:0] pred_hist_o,
    input logic [IDX_W-1:0]  fetch_idx,
    input logic [IDX_W-1:0]  upd_idx,
    input ctr_t              fetch_ctr,
    input ctr_t              upd_ctr_old,
    input ctr_t              upd_ctr_new
);
    logic             rst_q;
    logic             wr_q;
    logic [IDX_W-1:0] wr_idx_q;
    ctr_t             wr_ctr_q;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst) begin
            wr_q     <= 1'b0;
            wr_idx_q <= '0;
            wr_ctr_q <= CTR_RESET;
        end else begin
            wr_q     <= upd_valid_i;
            wr_idx_q <= upd_idx;
            wr_ctr_q <= upd_ctr_new;
        end
    end

    // R1: history is clear in the first cycle after reset
    always_ff @(posedge clk) begin
        if (rst_q && !rst) begin
            assert_hist_clear_R1: assert (pred_hist_o == '0)
                else $error("history not cleared after reset");
        end
    end

    // R9: a written counter is what a later fetch of that entry reads
    always_ff @(posedge clk) begin
        if (!rst && wr_q && fetch_idx == wr_idx_q) begin
            assert_write_visible_R9: assert (fetch_ctr == wr_ctr_q)
                else $error("counter write not visible to fetch");
        end
    end

    assert_hist_shift_R3: assert property (@(posedge clk) disable iff (rst)
        upd_valid_i |=> pred_hist_o == {$past(pred_hist_o[HIST_W-2:0]), $past(upd_taken_i)});

    assert_hist_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !upd_valid_i |=> $stable(pred_hist_o));

    assert_sat_top_R4: assert property (@(posedge clk) disable iff (rst)
        (upd_valid_i && upd_taken_i && upd_ctr_old == 2'b11) |-> upd_ctr_new == 2'b11);

    assert_sat_bot_R4: assert property (@(posedge clk) disable iff (rst)
        (upd_valid_i && !upd_taken_i && upd_ctr_old == 2'b00) |-> upd_ctr_new == 2'b00);

    assert_strong_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (upd_valid_i && upd_ctr_old[1] == upd_ctr_old[0] && upd_taken_i != upd_ctr_old[1])
            |-> upd_ctr_new[1] == upd_ctr_old[1]);
endmodule

bind gbp_top gbp_checker #(.IDX_W(IDX_W), .HIST_W(HIST_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .upd_valid_i (upd_valid_i),
    .upd_taken_i (upd_taken_i),
    .pred_hist_o (pred_hist_o),
    .fetch_idx   (fetch_idx),
    .upd_idx     (upd_idx),
    .fetch_ctr   (fetch_ctr),
    .upd_ctr_old (upd_ctr_old),
    .upd_ctr_new (upd_ctr_new)
);

// File: tb/tb_gbp_top.sv
module tb_gbp_top;
    localparam int PC_W = 32, PC_LSB = 2, IDX_W = 11, HIST_W = 8, PART_HIST_W = 4;
    localparam int DEPTH = 1 << IDX_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              mode_i = 1'b0;
    logic [PC_W-1:0]   fetch_pc_i = '0;
    logic              pred_taken_o;
    logic [HIST_W-1:0] pred_hist_o;
    logic              upd_valid_i = 1'b0;
    logic [PC_W-1:0]   upd_pc_i = '0;
    logic [HIST_W-1:0] upd_hist_i = '0;
    logic              upd_taken_i = 1'b0;

    always #5 clk = ~clk;

    gbp_top #(.PC_W(PC_W), .PC_LSB(PC_LSB), .IDX_W(IDX_W), .HIST_W(HIST_W),
              .PART_HIST_W(PART_HIST_W)) dut (
        .clk(clk), .rst(rst), .mode_i(mode_i), .fetch_pc_i(fetch_pc_i),
        .pred_taken_o(pred_taken_o), .pred_hist_o(pred_hist_o),
        .upd_valid_i(upd_valid_i), .upd_pc_i(upd_pc_i), .upd_hist_i(upd_hist_i),
        .upd_taken_i(upd_taken_i)
    );

    typedef struct {
        logic              taken;
        logic [HIST_W-1:0] hist;
        string             tag;
    } exp_t;

    exp_t              sb[$];
    logic [1:0]        model [DEPTH];
    logic [HIST_W-1:0] mhist;
    int                n_cmp = 0;
    int                n_bad = 0;
    bit                done = 0;
    event              mon_ev;

    function automatic logic [IDX_W-1:0] ref_idx(input logic md, input logic [PC_W-1:0] pc,
                                                  input logic [HIST_W-1:0] h);
        logic [IDX_W-1:0] p;
        p = pc[PC_LSB +: IDX_W];
        if (md) return p ^ {{(IDX_W-HIST_W){1'b0}}, h};
        return {h[PART_HIST_W-1:0], p[IDX_W-PART_HIST_W-1:0]};
    endfunction

    task automatic step(input logic md, input logic [PC_W-1:0] fpc, input logic uv,
                        input logic [PC_W-1:0] upc, input logic [HIST_W-1:0] uh,
                        input logic ut, input string tag);
        exp_t e;
        logic [IDX_W-1:0] ui;
        @(negedge clk);
        mode_i = md; fetch_pc_i = fpc; upd_valid_i = uv;
        upd_pc_i = upc; upd_hist_i = uh; upd_taken_i = ut;
        e.taken = model[ref_idx(md, fpc, mhist)][1];
        e.hist  = mhist;
        e.tag   = tag;
        sb.push_back(e);
        -> mon_ev;
        if (uv) begin
            ui = ref_idx(md, upc, uh);
            if (ut) model[ui] = (model[ui] == 2'b11) ? 2'b11 : model[ui] + 2'd1;
            else    model[ui] = (model[ui] == 2'b00) ? 2'b00 : model[ui] - 2'd1;
            mhist = {mhist[HIST_W-2:0], ut};
        end
        @(posedge clk);
        #1 upd_valid_i = 1'b0;
    endtask

    // monitor: pops the expected item and compares with the outputs
    always begin
        exp_t e;
        @(mon_ev);
        #1;
        e = sb.pop_front();
        n_cmp++;
        if (pred_taken_o !== e.taken || pred_hist_o !== e.hist) begin
            n_bad++;
            $display("FAIL %s: got taken=%0b hist=%02h expected taken=%0b hist=%02h",
                     e.tag, pred_taken_o, pred_hist_o, e.taken, e.hist);
        end
    end

    // drive history to an exact value through updates of a far branch
    task automatic load_hist(input logic md, input logic [HIST_W-1:0] v);
        for (int i = HIST_W - 1; i >= 0; i--) begin
            step(md, 32'h0000_7F00, 1'b1, 32'h0000_7F00, mhist, v[i], "R3 load");
        end
    endtask

    initial begin
        logic [31:0] lfsr;
        logic [PC_W-1:0] a;
        logic [HIST_W-1:0] snap;
        for (int i = 0; i < DEPTH; i++) model[i] = 2'b01;
        mhist = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state, both modes
        step(1'b0, 32'h0000_0100, 1'b0, '0, '0, 1'b0, "R1 reset part");
        step(1'b1, 32'h0000_0ABC, 1'b0, '0, '0, 1'b0, "R1 reset hash");
        step(1'b1, 32'hFFFF_FFFC, 1'b0, '0, '0, 1'b0, "R1 R10 reset hist");

        // R3 history shift observed on pred_hist_o
        step(1'b1, 32'h0000_0200, 1'b1, 32'h0000_0300, 8'h00, 1'b1, "R3 shift 1");
        step(1'b1, 32'h0000_0200, 1'b1, 32'h0000_0300, 8'h01, 1'b0, "R3 shift 0");
        step(1'b1, 32'h0000_0200, 1'b0, '0, '0, 1'b0, "R3 R10 hold");

        // R4 R5 hashed: saturate taken, one excursion keeps taken, second flips
        load_hist(1'b1, 8'h00);
        a = 32'h0000_1000;
        for (int i = 0; i < 4; i++) step(1'b1, a, 1'b1, a, 8'h00, 1'b1, "R4 train taken");
        load_hist(1'b1, 8'h00);
        step(1'b1, a, 1'b1, a, 8'h00, 1'b0, "R2 strong taken");
        load_hist(1'b1, 8'h00);
        step(1'b1, a, 1'b1, a, 8'h00, 1'b0, "R5 one excursion still taken");
        load_hist(1'b1, 8'h00);
        step(1'b1, a, 1'b0, '0, '0, 1'b0, "R5 second miss flips");
        for (int i = 0; i < 4; i++) step(1'b1, a, 1'b1, a, 8'h00, 1'b0, "R4 drain");
        step(1'b1, a, 1'b1, a, 8'h00, 1'b1, "R4 floor");
        load_hist(1'b1, 8'h00);
        step(1'b1, a, 1'b0, '0, '0, 1'b0, "R4 R5 from floor one taken stays not-taken");

        // R8 snapshot training, R7 hashed
        snap = 8'hA5;
        a = 32'h0000_2040;
        step(1'b1, a, 1'b1, a, snap, 1'b1, "R8 train snap");
        step(1'b1, a, 1'b1, a, snap, 1'b1, "R8 train snap");
        load_hist(1'b1, snap);
        step(1'b1, a, 1'b0, '0, '0, 1'b0, "R8 R7 snapshot entry taken");

        // R6 partitioned: same pc, different sub-table
        step(1'b0, a, 1'b1, a, 8'h03, 1'b1, "R6 train sub3");
        step(1'b0, a, 1'b1, a, 8'h03, 1'b1, "R6 train sub3");
        load_hist(1'b0, 8'hF3);
        step(1'b0, a, 1'b0, '0, '0, 1'b0, "R6 sub3 taken");
        load_hist(1'b0, 8'hF4);
        step(1'b0, a, 1'b0, '0, '0, 1'b0, "R6 sub4 untouched");

        // R9 same-cycle collision: fetch sees the old counter
        load_hist(1'b1, 8'h3C);
        a = 32'h0000_0444;
        step(1'b1, a, 1'b1, a, 8'h3C, 1'b1, "R9 collision old value");

        // mixed traffic in both modes
        lfsr = 32'hACE1_1357;
        for (int i = 0; i < 600; i++) begin
            logic md;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            md = lfsr[7];
            step(md, {19'd0, lfsr[12:0]} & 32'h0000_03FC, lfsr[3],
                 {19'd0, lfsr[28:16]} & 32'h0000_03FC,
                 lfsr[5] ? mhist : lfsr[27:20], lfsr[9] | lfsr[10],
                 md ? "R2 R7 mixed" : "R2 R6 mixed");
        end

        repeat (3) @(posedge clk);
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule